// File: doc/BRIEF.md
# Radix Bucket Burst Distributor

This block carries out one distribution pass of a radix bucket sort. It reads keys out of an external word memory, one fixed-size cell per burst. It picks out one digit of each key, selected by a pass number, and appends the key to a small on-chip FIFO for that digit's bucket. When a bucket has collected a whole burst of words, the oldest words are written back to memory as one write burst. The target is a cell taken from a free list. Input cells join that free list as soon as they have been read completely, so the output mostly reuses the space of the input. In the simplest setup only a few spare cells are needed on top of it.

Each bucket's output cells are chained into a singly linked list. The block keeps a head pointer, a tail pointer and a cell count for every bucket, plus a per-cell link word and a per-cell valid-word count. When the input is exhausted, every bucket that still holds words is flushed as a final short cell. The block then raises `done`. The next pass, and any software check, walks the lists through a small combinational query port.

A pass is started by a one-cycle `start` pulse, which carries:
- the pass number;
- the contiguous run of input cells, with the number of valid words in the last of them;
- a contiguous run of spare cells that seeds the free list.

Memory accepts one access per cycle. Read data is returned on the cycle after the read address.

Top module: `radix_dist_engine`

## Requirements
- R1: The bucket of a key is the digit `key[DIGIT_W*pass +: DIGIT_W]`, where `pass` is the value latched at `start`. There are 2**DIGIT_W buckets, and within each bucket keys keep their input order.
- R2: Memory traffic consists only of bursts. A burst issues consecutive word addresses of one cell (address = cell*BURST_LEN + word), one per cycle, starting at word 0. It is all reads or all writes and never longer than BURST_LEN.
- R3: Each bucket FIFO holds 2*BURST_LEN words and never overflows. A read burst starts only while no bucket holds more than BURST_LEN words.
- R4: Whenever some bucket holds at least BURST_LEN words, no read burst is issued until a write burst of exactly BURST_LEN of its oldest words has been done. Such a cell records a valid count of BURST_LEN.
- R5: Output cells of a bucket form a list: `rd_head` gives the first cell, `rd_len` the number of cells, and `rd_next` of each cell the next one. The last cell links to itself.
- R6: A fully read input cell becomes available for output. Every output cell is either an input cell or a spare cell, and no cell is used twice.
- R7: After the input is exhausted, each bucket holding 1 to BURST_LEN-1 words is flushed as one final cell whose `rd_cnt` equals that word count. A bucket with n keys therefore has ceil(n/BURST_LEN) cells.
- R8: Input in which all keys have the same digit is distributed correctly, with every other bucket left with `rd_len` 0.
- R9: `done` goes high only after all input has been read and all flushes have been written. It stays high with no memory access until the next `start`, and is low in the cycle after `start`.
- R10: Out of reset, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins a pass; accepted when idle or done |
| pass_idx | input | PASS_W | Digit position for this pass |
| in_first | input | CELL_W | First input cell |
| in_cells | input | CELL_W+1 | Number of input cells |
| in_last_words | input | CNT_W | Valid words in the last input cell (1..BURST_LEN) |
| spare_first | input | CELL_W | First spare cell |
| spare_cells | input | CELL_W+1 | Number of spare cells |
| done | output | 1 | Pass complete |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | CELL_W+OFF_W | Word address |
| mem_wdata | output | KEY_W | Write data |
| mem_rdata | input | KEY_W | Read data, valid the cycle after a read |
| rd_bkt | input | DIGIT_W | Bucket queried |
| rd_head | output | CELL_W | First cell of the queried bucket |
| rd_len | output | CELL_W+1 | Cell count of the queried bucket |
| rd_cell | input | CELL_W | Cell queried |
| rd_next | output | CELL_W | Link word of the queried cell |
| rd_cnt | output | CNT_W | Valid words in the queried cell |

## Verification
The bench builds the block with 16-bit keys, 2-bit digits (four buckets), 4-word bursts and 32 cells. At this size a pass of a few dozen keys fills buckets past the burst threshold several times. It also forces several buckets over threshold together, ends with partial buckets to flush, and, in one run, leaves only one more spare cell than there are buckets, so output must reuse freed input cells. The digit positions used include the lowest, a middle and the topmost one. There is also a skewed run with a single live bucket and a run of a single one-word cell.

// File: rtl/rdx_pkg.sv
package rdx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_SCHED,
    ST_READ,
    ST_DRAIN,
    ST_WRITE,
    ST_DONE
  } eng_state_e;

endpackage

// File: rtl/rdx_rr_arb.sv
module rdx_rr_arb #(
  parameter int N     = 256,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [N-1:0]     req,
  input  logic             adv,
  output logic [IDX_W-1:0] gnt_idx,
  output logic             gnt_vld
);

  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0] cand;

  // search from the rotating pointer; lowest offset wins
  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    cand    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      cand = ptr_q + IDX_W'(i);
      if (req[cand]) begin
        gnt_vld = 1'b1;
        gnt_idx = cand;
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (clr)
      ptr_d = '0;
    else if (adv && gnt_vld)
      ptr_d = gnt_idx + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

endmodule

// File: rtl/rdx_bucket_buf.sv
module rdx_bucket_buf #(
  parameter int KEY_W     = 64,
  parameter int BKT_W     = 8,
  parameter int BURST_LEN = 8,
  parameter int FILL_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [BKT_W-1:0]  push_bkt,
  input  logic [KEY_W-1:0]  push_key,
  input  logic              pop,
  input  logic [BKT_W-1:0]  pop_bkt,
  output logic [KEY_W-1:0]  pop_key,
  input  logic [BKT_W-1:0]  sel_bkt,
  output logic [FILL_W-1:0] sel_fill,
  output logic [(1<<BKT_W)-1:0] full_vec,
  output logic [(1<<BKT_W)-1:0] busy_vec,
  output logic              hold
);

  localparam int NBKT  = 1 << BKT_W;
  localparam int DEPTH = 2 * BURST_LEN;
  localparam int PTR_W = $clog2(DEPTH);

  logic [KEY_W-1:0]  store [NBKT*DEPTH];
  logic [PTR_W-1:0]  wp_a  [NBKT];
  logic [PTR_W-1:0]  rp_a  [NBKT];
  logic [FILL_W-1:0] fill_a [NBKT];
  logic [NBKT-1:0]   over_vec;

  genvar b;
  generate
    for (b = 0; b < NBKT; b++) begin : g_bkt
      logic [PTR_W-1:0]  wp_q, wp_d, rp_q, rp_d;
      logic [FILL_W-1:0] fill_q, fill_d;
      logic              psh, pp;

      assign psh = push && (push_bkt == BKT_W'(b));
      assign pp  = pop  && (pop_bkt  == BKT_W'(b));

      always_comb begin
        wp_d   = wp_q;
        rp_d   = rp_q;
        fill_d = fill_q;
        if (clr) begin
          wp_d   = '0;
          rp_d   = '0;
          fill_d = '0;
        end else begin
          if (psh) wp_d = wp_q + PTR_W'(1);
          if (pp)  rp_d = rp_q + PTR_W'(1);
          fill_d = fill_q + FILL_W'(psh) - FILL_W'(pp);
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          wp_q   <= '0;
          rp_q   <= '0;
          fill_q <= '0;
        end else begin
          wp_q   <= wp_d;
          rp_q   <= rp_d;
          fill_q <= fill_d;
        end
      end

      assign wp_a[b]     = wp_q;
      assign rp_a[b]     = rp_q;
      assign fill_a[b]   = fill_q;
      assign full_vec[b] = fill_q >= FILL_W'(BURST_LEN);
      assign busy_vec[b] = fill_q != '0;
      assign over_vec[b] = fill_q > FILL_W'(DEPTH - BURST_LEN);

      // R3: a FIFO never takes a word while already holding DEPTH words
      a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        psh |-> (fill_q < FILL_W'(DEPTH)));
      // R4: a write burst never drains a word that is not there
      a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pp |-> (fill_q != '0));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (push) store[{push_bkt, wp_a[push_bkt]}] <= push_key;
  end

  assign pop_key  = store[{pop_bkt, rp_a[pop_bkt]}];
  assign sel_fill = fill_a[sel_bkt];
  assign hold     = |over_vec;

endmodule

// File: rtl/rdx_cell_lists.sv
module rdx_cell_lists #(
  parameter int BKT_W  = 8,
  parameter int CELL_W = 8,
  parameter int CNT_W  = 4,
  parameter int LEN_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  // free cell pool
  input  logic              fl_push,
  input  logic [CELL_W-1:0] fl_push_cell,
  input  logic              fl_pop,
  output logic [CELL_W-1:0] fl_cell,
  output logic              fl_empty,
  // append a written cell to a bucket list
  input  logic              lk_en,
  input  logic [BKT_W-1:0]  lk_bkt,
  input  logic [CELL_W-1:0] lk_cell,
  input  logic [CNT_W-1:0]  lk_cnt,
  // query port
  input  logic [BKT_W-1:0]  q_bkt,
  output logic [CELL_W-1:0] q_head,
  output logic [LEN_W-1:0]  q_len,
  input  logic [CELL_W-1:0] q_cell,
  output logic [CELL_W-1:0] q_next,
  output logic [CNT_W-1:0]  q_cnt
);

  localparam int NBKT  = 1 << BKT_W;
  localparam int NCELL = 1 << CELL_W;

  logic [CELL_W-1:0] fmem    [NCELL];
  logic [CELL_W-1:0] nxt_mem [NCELL];
  logic [CNT_W-1:0]  cnt_mem [NCELL];
  logic [CELL_W-1:0] head_q  [NBKT];
  logic [CELL_W-1:0] tail_q  [NBKT];
  logic [LEN_W-1:0]  len_q   [NBKT];

  logic [CELL_W-1:0] fhd_q, fhd_d, ftl_q, ftl_d;
  logic [CELL_W:0]   fcnt_q, fcnt_d;

  always_comb begin
    fhd_d  = fhd_q;
    ftl_d  = ftl_q;
    fcnt_d = fcnt_q;
    if (clr) begin
      fhd_d  = '0;
      ftl_d  = '0;
      fcnt_d = '0;
    end else begin
      if (fl_push) ftl_d = ftl_q + CELL_W'(1);
      if (fl_pop)  fhd_d = fhd_q + CELL_W'(1);
      fcnt_d = fcnt_q + (CELL_W+1)'(fl_push) - (CELL_W+1)'(fl_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fhd_q  <= '0;
      ftl_q  <= '0;
      fcnt_q <= '0;
    end else begin
      fhd_q  <= fhd_d;
      ftl_q  <= ftl_d;
      fcnt_q <= fcnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fl_push) fmem[ftl_q] <= fl_push_cell;
  end

  assign fl_cell  = fmem[fhd_q];
  assign fl_empty = (fcnt_q == '0);

  // list link storage; the newest cell points at itself
  always_ff @(posedge clk) begin
    if (lk_en) begin
      nxt_mem[lk_cell] <= lk_cell;
      cnt_mem[lk_cell] <= lk_cnt;
      if (len_q[lk_bkt] != '0) nxt_mem[tail_q[lk_bkt]] <= lk_cell;
      else                     head_q[lk_bkt]          <= lk_cell;
      tail_q[lk_bkt] <= lk_cell;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBKT; i++) len_q[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < NBKT; i++) len_q[i] <= '0;
    end else if (lk_en) begin
      len_q[lk_bkt] <= len_q[lk_bkt] + LEN_W'(1);
    end
  end

  assign q_head = head_q[q_bkt];
  assign q_len  = len_q[q_bkt];
  assign q_next = nxt_mem[q_cell];
  assign q_cnt  = cnt_mem[q_cell];

  // R6: a cell is never taken from an empty pool, and the pool never overfills
  a_r6_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    fl_pop |-> (fcnt_q != '0));
  a_r6_push_room: assert property (@(posedge clk) disable iff (!rst_n)
    fl_push |-> (fcnt_q != (CELL_W+1)'(NCELL)));

endmodule

// File: rtl/radix_dist_engine.sv
module radix_dist_engine #(
  parameter int KEY_W     = 64,
  parameter int DIGIT_W   = 8,
  parameter int BURST_LEN = 8,
  parameter int CELL_W    = 8,
  parameter int PASS_W    = $clog2(KEY_W / DIGIT_W),
  parameter int OFF_W     = $clog2(BURST_LEN),
  parameter int CNT_W     = $clog2(BURST_LEN + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [PASS_W-1:0]       pass_idx,
  input  logic [CELL_W-1:0]       in_first,
  input  logic [CELL_W:0]         in_cells,
  input  logic [CNT_W-1:0]        in_last_words,
  input  logic [CELL_W-1:0]       spare_first,
  input  logic [CELL_W:0]         spare_cells,
  output logic                    done,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [CELL_W+OFF_W-1:0] mem_addr,
  output logic [KEY_W-1:0]        mem_wdata,
  input  logic [KEY_W-1:0]        mem_rdata,
  input  logic [DIGIT_W-1:0]      rd_bkt,
  output logic [CELL_W-1:0]       rd_head,
  output logic [CELL_W:0]         rd_len,
  input  logic [CELL_W-1:0]       rd_cell,
  output logic [CELL_W-1:0]       rd_next,
  output logic [CNT_W-1:0]        rd_cnt
);

  import rdx_pkg::*;

  localparam int NBKT   = 1 << DIGIT_W;
  localparam int DEPTH  = 2 * BURST_LEN;
  localparam int FILL_W = $clog2(DEPTH + 1);
  localparam int LEN_W  = CELL_W + 1;

  // reset: asynchronous assert, synchronous release
  logic rs_meta, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rst_n_s <= rs_meta;
    end
  end

  eng_state_e        state_q, state_d;
  logic [PASS_W-1:0] pass_q, pass_d;
  logic [CELL_W-1:0] in_ptr_q, in_ptr_d;
  logic [LEN_W-1:0]  in_left_q, in_left_d;
  logic [CNT_W-1:0]  last_w_q, last_w_d;
  logic [CELL_W-1:0] sp_ptr_q, sp_ptr_d;
  logic [LEN_W-1:0]  sp_left_q, sp_left_d;
  logic [CNT_W-1:0]  widx_q, widx_d;
  logic [CNT_W-1:0]  blen_q, blen_d;
  logic [CELL_W-1:0] cell_q, cell_d;
  logic [DIGIT_W-1:0] bkt_q, bkt_d;
  logic              rvld_q, rvld_d;

  logic              clr;
  logic              fl_push, fl_pop, fl_empty;
  logic [CELL_W-1:0] fl_push_cell, fl_cell;
  logic              lk_en;
  logic              bpop;
  logic [KEY_W-1:0]  pop_key;
  logic [FILL_W-1:0] sel_fill;
  logic [NBKT-1:0]   full_vec, busy_vec, arb_req;
  logic              hold, any_full;
  logic              arb_adv, gnt_vld;
  logic [DIGIT_W-1:0] gnt_idx;
  logic [DIGIT_W-1:0] in_digit;
  logic              last_word;

  assign any_full  = |full_vec;
  assign arb_req   = any_full ? full_vec : busy_vec;
  assign in_digit  = mem_rdata[DIGIT_W*pass_q +: DIGIT_W];
  assign last_word = (widx_q + CNT_W'(1)) == blen_q;

  rdx_rr_arb #(.N(NBKT), .IDX_W(DIGIT_W)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clr     (clr),
    .req     (arb_req),
    .adv     (arb_adv),
    .gnt_idx (gnt_idx),
    .gnt_vld (gnt_vld)
  );

  rdx_bucket_buf #(
    .KEY_W(KEY_W), .BKT_W(DIGIT_W), .BURST_LEN(BURST_LEN), .FILL_W(FILL_W)
  ) u_bufs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .clr      (clr),
    .push     (rvld_q),
    .push_bkt (in_digit),
    .push_key (mem_rdata),
    .pop      (bpop),
    .pop_bkt  (bkt_q),
    .pop_key  (pop_key),
    .sel_bkt  (gnt_idx),
    .sel_fill (sel_fill),
    .full_vec (full_vec),
    .busy_vec (busy_vec),
    .hold     (hold)
  );

  rdx_cell_lists #(
    .BKT_W(DIGIT_W), .CELL_W(CELL_W), .CNT_W(CNT_W), .LEN_W(LEN_W)
  ) u_lists (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .clr          (clr),
    .fl_push      (fl_push),
    .fl_push_cell (fl_push_cell),
    .fl_pop       (fl_pop),
    .fl_cell      (fl_cell),
    .fl_empty     (fl_empty),
    .lk_en        (lk_en),
    .lk_bkt       (bkt_q),
    .lk_cell      (cell_q),
    .lk_cnt       (blen_q),
    .q_bkt        (rd_bkt),
    .q_head       (rd_head),
    .q_len        (rd_len),
    .q_cell       (rd_cell),
    .q_next       (rd_next),
    .q_cnt        (rd_cnt)
  );

  always_comb begin
    state_d      = state_q;
    pass_d       = pass_q;
    in_ptr_d     = in_ptr_q;
    in_left_d    = in_left_q;
    last_w_d     = last_w_q;
    sp_ptr_d     = sp_ptr_q;
    sp_left_d    = sp_left_q;
    widx_d       = widx_q;
    blen_d       = blen_q;
    cell_d       = cell_q;
    bkt_d        = bkt_q;
    rvld_d       = (state_q == ST_READ);
    clr          = 1'b0;
    fl_push      = 1'b0;
    fl_push_cell = cell_q;
    fl_pop       = 1'b0;
    arb_adv      = 1'b0;
    lk_en        = 1'b0;
    bpop         = 1'b0;
    mem_req      = 1'b0;
    mem_we       = 1'b0;
    mem_addr     = {cell_q, widx_q[OFF_W-1:0]};
    mem_wdata    = pop_key;

    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          pass_d    = pass_idx;
          in_ptr_d  = in_first;
          in_left_d = in_cells;
          last_w_d  = in_last_words;
          sp_ptr_d  = spare_first;
          sp_left_d = spare_cells;
          clr       = 1'b1;
          state_d   = ST_INIT;
        end
      end

      ST_INIT: begin
        if (sp_left_q != '0) begin
          fl_push      = 1'b1;
          fl_push_cell = sp_ptr_q;
          sp_ptr_d     = sp_ptr_q + CELL_W'(1);
          sp_left_d    = sp_left_q - LEN_W'(1);
        end else begin
          state_d = ST_SCHED;
        end
      end

      ST_SCHED: begin
        widx_d = '0;
        if (any_full) begin
          // a full block always goes out before more input comes in
          if (!fl_empty) begin
            fl_pop  = 1'b1;
            arb_adv = 1'b1;
            cell_d  = fl_cell;
            bkt_d   = gnt_idx;
            blen_d  = CNT_W'(BURST_LEN);
            state_d = ST_WRITE;
          end
        end else if (in_left_q != '0) begin
          if (!hold) begin
            cell_d    = in_ptr_q;
            in_ptr_d  = in_ptr_q + CELL_W'(1);
            in_left_d = in_left_q - LEN_W'(1);
            blen_d    = (in_left_q == LEN_W'(1)) ? last_w_q : CNT_W'(BURST_LEN);
            state_d   = ST_READ;
          end
        end else if (gnt_vld) begin
          // end of input: flush a partial bucket as a short cell
          if (!fl_empty) begin
            fl_pop  = 1'b1;
            arb_adv = 1'b1;
            cell_d  = fl_cell;
            bkt_d   = gnt_idx;
            blen_d  = CNT_W'(sel_fill);
            state_d = ST_WRITE;
          end
        end else begin
          state_d = ST_DONE;
        end
      end

      ST_READ: begin
        mem_req = 1'b1;
        widx_d  = widx_q + CNT_W'(1);
        if (last_word) state_d = ST_DRAIN;
      end

      ST_DRAIN: begin
        // last word lands this cycle; the input cell is now free
        fl_push = 1'b1;
        state_d = ST_SCHED;
      end

      ST_WRITE: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        bpop    = 1'b1;
        widx_d  = widx_q + CNT_W'(1);
        if (last_word) begin
          lk_en   = 1'b1;
          state_d = ST_SCHED;
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q   <= ST_IDLE;
      pass_q    <= '0;
      in_ptr_q  <= '0;
      in_left_q <= '0;
      last_w_q  <= '0;
      sp_ptr_q  <= '0;
      sp_left_q <= '0;
      widx_q    <= '0;
      blen_q    <= '0;
      cell_q    <= '0;
      bkt_q     <= '0;
      rvld_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      pass_q    <= pass_d;
      in_ptr_q  <= in_ptr_d;
      in_left_q <= in_left_d;
      last_w_q  <= last_w_d;
      sp_ptr_q  <= sp_ptr_d;
      sp_left_q <= sp_left_d;
      widx_q    <= widx_d;
      blen_q    <= blen_d;
      cell_q    <= cell_d;
      bkt_q     <= bkt_d;
      rvld_q    <= rvld_d;
    end
  end

  assign done = (state_q == ST_DONE);

  // R2: inside a burst, addresses step by one and direction does not change
  a_r2_burst_contig: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_req && $past(mem_req) && (mem_addr[OFF_W-1:0] != '0)) |->
      ((mem_addr == $past(mem_addr) + 1'b1) && (mem_we == $past(mem_we))));
  // R3: a read burst opens only when every FIFO has room for a whole burst
  a_r3_read_holdoff: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_req && !mem_we && (mem_addr[OFF_W-1:0] == '0)) |-> !hold);
  // R4: no read burst opens while a bucket holds a full block
  a_r4_full_first: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_req && !mem_we && (mem_addr[OFF_W-1:0] == '0)) |-> !any_full);
  // R9: no memory activity once the pass is reported done
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |-> !mem_req);

endmodule

// File: tb/sim_radix_dist_engine.sv
module sim_radix_dist_engine;

  localparam int KEY_W  = 16;
  localparam int DIG_W  = 2;
  localparam int BL     = 4;
  localparam int CW     = 5;
  localparam int PW     = 3;
  localparam int OW     = 2;
  localparam int CNTW   = 3;
  localparam int NB     = 1 << DIG_W;
  localparam int NC     = 1 << CW;
  localparam int NWORDS = NC * BL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [PW-1:0] pass_idx = '0;
  logic [CW-1:0] in_first = '0;
  logic [CW:0]   in_cells = '0;
  logic [CNTW-1:0] in_last_words = '0;
  logic [CW-1:0] spare_first = '0;
  logic [CW:0]   spare_cells = '0;
  logic done, mem_req, mem_we;
  logic [CW+OW-1:0] mem_addr;
  logic [KEY_W-1:0] mem_wdata;
  logic [KEY_W-1:0] mem_rdata = '0;
  logic [DIG_W-1:0] rd_bkt = '0;
  logic [CW-1:0] rd_head;
  logic [CW:0]   rd_len;
  logic [CW-1:0] rd_cell = '0;
  logic [CW-1:0] rd_next;
  logic [CNTW-1:0] rd_cnt;

  int checks = 0;
  int failures = 0;

  logic [KEY_W-1:0] mem [NWORDS];
  logic [KEY_W-1:0] inkeys [NWORDS];
  int nin;
  bit allowed [NC];
  int viol = 0;
  logic prev_req = 1'b0, prev_we = 1'b0;
  logic [CW+OW-1:0] prev_addr = '0;

  always #10 clk = ~clk;

  radix_dist_engine #(
    .KEY_W(KEY_W), .DIGIT_W(DIG_W), .BURST_LEN(BL), .CELL_W(CW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pass_idx(pass_idx),
    .in_first(in_first), .in_cells(in_cells), .in_last_words(in_last_words),
    .spare_first(spare_first), .spare_cells(spare_cells), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rd_bkt(rd_bkt),
    .rd_head(rd_head), .rd_len(rd_len), .rd_cell(rd_cell),
    .rd_next(rd_next), .rd_cnt(rd_cnt)
  );

  // word memory with one-cycle read latency, plus a burst-shape monitor
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata     <= mem[mem_addr];
      if (mem_addr[OW-1:0] != '0) begin
        if (!(prev_req && prev_we == mem_we && mem_addr == prev_addr + 1'b1))
          viol <= viol + 1;
      end
    end
    prev_req  <= mem_req;
    prev_we   <= mem_we;
    prev_addr <= mem_addr;
  end

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog: run did not finish (actual=running expected=finished)");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int digit_of(input logic [KEY_W-1:0] k, input int p);
    return int'((k >> (DIG_W * p)) & ((1 << DIG_W) - 1));
  endfunction

  // run one pass and check every list against the input, in order
  task automatic run_pass(input int p, input int first, input int ncell,
                          input int lastw, input int spf, input int spn);
    int wait_cyc;
    int v0;
    bit used [NC];
    logic [KEY_W-1:0] expk [NWORDS];
    int ne, ecells, pos, c, cnt_exp, bad_word, bad_act, bad_exp, lastc;
    for (int i = 0; i < NC; i++) begin
      used[i] = 1'b0;
      allowed[i] = ((i >= first && i < first + ncell) || (i >= spf && i < spf + spn));
    end
    v0 = viol;
    @(negedge clk);
    pass_idx = PW'(p); in_first = CW'(first); in_cells = (CW+1)'(ncell);
    in_last_words = CNTW'(lastw); spare_first = CW'(spf); spare_cells = (CW+1)'(spn);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R9", "done low after start", int'(done), 0);
    wait_cyc = 0;
    while (!done && wait_cyc < 20000) begin
      @(negedge clk);
      wait_cyc++;
    end
    chk(done == 1'b1, "R9", "done reached", int'(done), 1);
    repeat (3) @(negedge clk);
    chk(done == 1'b1 && mem_req == 1'b0, "R9", "done holds, bus quiet",
        int'(mem_req), 0);
    chk(viol == v0, "R2", "burst shape violations", viol - v0, 0);
    for (int b = 0; b < NB; b++) begin
      ne = 0;
      for (int i = 0; i < nin; i++)
        if (digit_of(inkeys[i], p) == b) begin expk[ne] = inkeys[i]; ne++; end
      ecells = (ne + BL - 1) / BL;
      rd_bkt = DIG_W'(b);
      #1;
      chk(int'(rd_len) == ecells, "R7", $sformatf("bucket %0d cell count", b),
          int'(rd_len), ecells);
      if (rd_len != '0 && int'(rd_len) == ecells) begin
        c = int'(rd_head);
        pos = 0; bad_word = -1; bad_act = 0; bad_exp = 0; lastc = 0;
        for (int j = 0; j < ecells; j++) begin
          rd_cell = CW'(c);
          #1;
          chk(allowed[c] && !used[c], "R6", $sformatf("bucket %0d cell %0d fresh", b, c),
              int'(used[c]), 0);
          used[c] = 1'b1;
          cnt_exp = (j == ecells - 1) ? ne - (ecells - 1) * BL : BL;
          chk(int'(rd_cnt) == cnt_exp, (j == ecells - 1) ? "R7" : "R4",
              $sformatf("bucket %0d cell %0d valid count", b, j), int'(rd_cnt), cnt_exp);
          for (int w = 0; w < cnt_exp; w++) begin
            if (bad_word < 0 && mem[c*BL + w] !== expk[pos]) begin
              bad_word = pos; bad_act = int'(mem[c*BL + w]); bad_exp = int'(expk[pos]);
            end
            pos++;
          end
          lastc = c;
          if (j < ecells - 1) c = int'(rd_next);
        end
        chk(int'(rd_next) == lastc, "R5", $sformatf("bucket %0d end self-link", b),
            int'(rd_next), lastc);
        chk(bad_word < 0, "R1", $sformatf("bucket %0d keys in order (pos %0d)", b, bad_word),
            bad_act, bad_exp);
      end
    end
  endtask

  task automatic load_input(input int first, input int ncell, input int lastw,
                            input int mul, input int add, input logic [KEY_W-1:0] clr_m,
                            input logic [KEY_W-1:0] set_m);
    logic [KEY_W-1:0] k;
    nin = (ncell - 1) * BL + lastw;
    for (int i = 0; i < nin; i++) begin
      k = KEY_W'(i * mul + add);
      k = (k & ~clr_m) | set_m;
      inkeys[i] = k;
      mem[first*BL + i] = k;
    end
  endtask

  task automatic test_reset();
    chk(done == 1'b0, "R10", "done after reset", int'(done), 0);
    chk(mem_req == 1'b0, "R10", "mem_req after reset", int'(mem_req), 0);
  endtask

  // mixed keys, lowest digit, tight spare pool forces reuse of input cells
  task automatic test_mixed_low();
    load_input(0, 6, 4, 2029, 77, '0, '0);
    run_pass(0, 0, 6, 4, 26, NB + 1);
  endtask

  // every key in digit 2 of a middle position, short last cell
  task automatic test_skew();
    load_input(8, 7, 3, 613, 9, 16'h0030, 16'h0020);
    run_pass(2, 8, 7, 3, 16, 8);
    for (int b = 0; b < NB; b++) begin
      if (b != 2) begin
        rd_bkt = DIG_W'(b);
        #1;
        chk(rd_len == '0, "R8", $sformatf("unused bucket %0d empty", b), int'(rd_len), 0);
      end
    end
  endtask

  // topmost digit, one-word last cell
  task automatic test_top_digit();
    load_input(2, 3, 1, 7919, 1234, '0, '0);
    run_pass(7, 2, 3, 1, 20, 8);
  endtask

  // a single one-word cell: one flush, no full block
  task automatic test_single_word();
    load_input(31, 1, 1, 1, 16'hC3A5, '0, '0);
    run_pass(3, 31, 1, 1, 0, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_mixed_low();
    test_skew();
    test_top_digit();
    test_single_word();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule